// File: doc/BRIEF.md
# Serial-Output SAR Conversion Controller

This block is the digital control for an 8-bit successive-approximation converter whose result leaves on a single serial line. Pulling chip select low starts a conversion. The sequencer then spends a short setup window with the serial line driven low. Next it resolves the code one bit at a time, most significant bit first. For each bit it presents a trial code to an external ladder or DAC and reads back a single comparator decision.

Each decision is registered on a falling edge of the serial clock. On that same edge the decision is also driven on the data line. This lets a host that samples on rising edges read the result while it is still being formed. When the last bit is known, the code also appears on a parallel output next to a done flag. Raising chip select clears every register and puts the data line into high impedance. A conversion only starts on a new falling edge of chip select.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While cs_ni is high, doe_o, done_o, trial_o and result_o are all 0.
- R2: During the first 3 falling edges of sclk_i after cs_ni falls, doe_o is 1 and dout_o is 0.
- R3: After falling edge k (k = 3..10), trial_o holds the bits already decided, plus a 1 at bit index 10-k, with every lower bit 0. The first bit tried is bit 7.
- R4: At falling edge k (k = 4..11), bit 11-k of the code takes the value of cmp_i sampled at that edge, and dout_o changes to that same value.
- R5: After falling edge 11, done_o is 1. result_o and trial_o both equal the final code, and dout_o keeps bit 0 of the code.
- R6: Further sclk_i edges with cs_ni held low change none of the outputs, and no new conversion starts.
- R7: Raising cs_ni before the conversion ends clears all outputs at once. The next fall of cs_ni restarts the sequence from the first setup edge.
- R8: result_o is 0 until done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock; state advances on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select; high clears all state |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above trial_o |
| trial_o | output | 8 | Trial code for the external ladder |
| dout_o | output | 1 | Serial result, MSB first |
| doe_o | output | 1 | Drive enable for the serial line (0 = high impedance) |
| done_o | output | 1 | Conversion complete |
| result_o | output | 8 | Final code, valid while done_o is 1 |

## Verification
A behavioural comparator in the bench resolves codes at both rails, at the midscale boundaries 0x80 and 0x7F, and at alternating bit patterns. Each of these patterns exposes a different error. A design whose bit order or trial-bit position was off by one would converge to a wrong code or shift the serial stream by one period. A design that left a stale trial bit set would fail on 0x7F.

For each conversion the scoreboard checks every falling-edge slot, both the serial bit and the trial code. A sequencer that shortened or lengthened the setup window would misalign the stream and miscompare there.

Chip select is also held low long after completion. A design that restarted or kept shifting would alter the outputs during that hold. Finally, a conversion is aborted midway and followed by a fresh one. A design that missed the asynchronous clear would carry stale code bits into the next result.

// File: rtl/sar_ser_pkg.sv
package sar_ser_pkg;
  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_BITS  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_ser_seq.sv
module sar_ser_seq
  import sar_ser_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SETUP = 3
) (
  input  logic                     sclk_i,
  input  logic                     clr_ni,
  output phase_e                   phase_o,
  output logic [$clog2(WIDTH)-1:0] bit_idx_o
);
  localparam int TOTAL = SETUP + WIDTH;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int IW    = $clog2(WIDTH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rem;

  always_ff @(negedge sclk_i or negedge clr_ni) begin
    if (!clr_ni)                  cnt_q <= '0;
    else if (cnt_q != CW'(TOTAL)) cnt_q <= cnt_q + 1'b1;
  end

  assign rem = CW'(TOTAL - 1) - cnt_q;

  always_comb begin
    bit_idx_o = '0;
    if (cnt_q < CW'(SETUP)) begin
      phase_o = PH_SETUP;
    end else if (cnt_q < CW'(TOTAL)) begin
      phase_o   = PH_BITS;
      bit_idx_o = rem[IW-1:0];
    end else begin
      phase_o = PH_DONE;
    end
  end

  AST_DONE_STICKY: assert property (@(negedge sclk_i) disable iff (!clr_ni)
    phase_o == PH_DONE |=> phase_o == PH_DONE); // R6
  AST_FIRST_BIT_MSB: assert property (@(negedge sclk_i) disable iff (!clr_ni)
    (phase_o == PH_BITS && $past(phase_o) == PH_SETUP) |-> bit_idx_o == IW'(WIDTH - 1)); // R3
endmodule

// File: rtl/sar_ser_reg.sv
module sar_ser_reg
  import sar_ser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     sclk_i,
  input  logic                     clr_ni,
  input  phase_e                   phase_i,
  input  logic [$clog2(WIDTH)-1:0] bit_idx_i,
  input  logic                     cmp_i,
  output logic [WIDTH-1:0]         trial_o,
  output logic [WIDTH-1:0]         code_o
);
  logic [WIDTH-1:0] sar_q;

  always_ff @(negedge sclk_i or negedge clr_ni) begin
    if (!clr_ni)                 sar_q <= '0;
    else if (phase_i == PH_BITS) sar_q[bit_idx_i] <= cmp_i;
  end

  always_comb begin
    trial_o = sar_q;
    if (phase_i == PH_BITS) trial_o[bit_idx_i] = 1'b1;
  end

  assign code_o = sar_q;

  AST_BIT_KEPT: assert property (@(negedge sclk_i) disable iff (!clr_ni)
    phase_i == PH_BITS |=> sar_q[$past(bit_idx_i)] == $past(cmp_i)); // R4
  AST_OPEN_BIT_CLEAR: assert property (@(negedge sclk_i) disable iff (!clr_ni)
    phase_i == PH_BITS |-> !sar_q[bit_idx_i]); // R3
  AST_CODE_FROZEN: assert property (@(negedge sclk_i) disable iff (!clr_ni)
    phase_i == PH_DONE |=> $stable(sar_q)); // R6
endmodule

// File: rtl/sar_ser_shift.sv
module sar_ser_shift
  import sar_ser_pkg::*;
(
  input  logic   sclk_i,
  input  logic   clr_ni,
  input  phase_e phase_i,
  input  logic   cmp_i,
  output logic   dout_o
);
  logic dout_q;

  always_ff @(negedge sclk_i or negedge clr_ni) begin
    if (!clr_ni) dout_q <= 1'b0;
    else begin
      unique case (phase_i)
        PH_SETUP: dout_q <= 1'b0;
        PH_BITS:  dout_q <= cmp_i;
        default:  dout_q <= dout_q;
      endcase
    end
  end

  assign dout_o = dout_q;

  AST_SETUP_LOW: assert property (@(negedge sclk_i) disable iff (!clr_ni)
    phase_i == PH_SETUP |-> !dout_q); // R2
  AST_LSB_HOLD: assert property (@(negedge sclk_i) disable iff (!clr_ni)
    phase_i == PH_DONE |=> $stable(dout_q)); // R5
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_ser_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SETUP = 3
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             dout_o,
  output logic             doe_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int IW = $clog2(WIDTH);

  logic             clr_n;
  phase_e           phase;
  logic [IW-1:0]    bit_idx;
  logic [WIDTH-1:0] code;

  // chip select high acts as an asynchronous clear
  assign clr_n = rst_ni & ~cs_ni;

  sar_ser_seq #(.WIDTH(WIDTH), .SETUP(SETUP)) u_seq (
    .sclk_i   (sclk_i),
    .clr_ni   (clr_n),
    .phase_o  (phase),
    .bit_idx_o(bit_idx)
  );

  sar_ser_reg #(.WIDTH(WIDTH)) u_reg (
    .sclk_i   (sclk_i),
    .clr_ni   (clr_n),
    .phase_i  (phase),
    .bit_idx_i(bit_idx),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .code_o   (code)
  );

  sar_ser_shift u_shift (
    .sclk_i (sclk_i),
    .clr_ni (clr_n),
    .phase_i(phase),
    .cmp_i  (cmp_i),
    .dout_o (dout_o)
  );

  assign doe_o    = clr_n;
  assign done_o   = (phase == PH_DONE);
  assign result_o = done_o ? code : '0;

  AST_DONE_MATCH: assert property (@(negedge sclk_i) disable iff (!clr_n)
    done_o |-> trial_o == result_o); // R5
  AST_RESULT_HIDDEN: assert property (@(negedge sclk_i) disable iff (!clr_n)
    (!done_o && $past(!done_o)) |-> result_o == '0); // R8
endmodule

// File: tb/sim_sar_serial_ctrl.sv
`timescale 1ns/1ps
module sim_sar_serial_ctrl;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [7:0] vin = 8'd0;
  logic       cmp;
  logic [7:0] trial, result;
  logic       dout, doe, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    logic       d;
    logic [7:0] t;
    logic [7:0] r;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 sclk = ~sclk;

  // behavioural comparator
  assign cmp = (vin >= trial);

  sar_serial_ctrl u0 (
    .sclk_i(sclk), .rst_ni(rst_n), .cs_ni(cs_n), .cmp_i(cmp),
    .trial_o(trial), .dout_o(dout), .doe_o(doe), .done_o(done), .result_o(result)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: one item per falling edge, compared at the next rising edge
  always @(posedge sclk) begin
    if (!cs_n && q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " doe"},    int'(doe),    1);
      chk({e.tag, " dout"},   int'(dout),   int'(e.d));
      chk({e.tag, " trial"},  int'(trial),  int'(e.t));
      chk({"R8 result"},      int'(result), int'(e.r));
    end
  end

  task automatic check_idle(string tag);
    chk({tag, " doe"},    int'(doe),    0);
    chk({tag, " done"},   int'(done),   0);
    chk({tag, " trial"},  int'(trial),  0);
    chk({tag, " result"}, int'(result), 0);
  endtask

  task automatic convert(logic [7:0] v);
    vin = v;
    for (int k = 1; k <= 11; k++) begin
      exp_t e;
      if (k <= 3) begin e.d = 1'b0; e.tag = "R2"; end
      else begin e.d = v[11-k]; e.tag = "R4"; end
      if (k < 3) e.t = 8'h00;
      else if (k <= 10) begin
        int b;
        b = 10 - k;
        e.t = 8'((int'(v) >> (b + 1)) << (b + 1)) | 8'(1 << b);
        if (k > 3) e.tag = "R3/R4";
        else e.tag = "R3";
      end else e.t = v;
      e.r = (k == 11) ? v : 8'h00;
      q.push_back(e);
    end
    @(posedge sclk); #1 cs_n = 1'b0;
    wait (q.size() == 0);
    @(posedge sclk); #0.5;
    chk("R5 done",   int'(done),   1);
    chk("R5 result", int'(result), int'(v));
    chk("R5 trial",  int'(trial),  int'(v));
    chk("R5 dout",   int'(dout),   int'(v[0]));
    repeat (6) @(posedge sclk);
    #0.5;
    chk("R6 done",   int'(done),   1);
    chk("R6 result", int'(result), int'(v));
    chk("R6 trial",  int'(trial),  int'(v));
    chk("R6 dout",   int'(dout),   int'(v[0]));
    #0.5 cs_n = 1'b1;
    #0.5 check_idle("R1");
    repeat (2) @(posedge sclk);
  endtask

  task automatic abort_run(logic [7:0] v);
    vin = v;
    @(posedge sclk); #1 cs_n = 1'b0;
    repeat (6) @(posedge sclk);
    #0.5;
    chk("R7 mid doe", int'(doe), 1);
    #0.5 cs_n = 1'b1;
    #0.5 check_idle("R7");
    repeat (2) @(posedge sclk);
  endtask

  initial begin
    #0.5 check_idle("R1");
    repeat (3) @(posedge sclk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge sclk);
    #0.5 check_idle("R1");
    convert(8'h00);
    convert(8'hFF);
    convert(8'h80);
    convert(8'h7F);
    convert(8'hA5);
    convert(8'h5A);
    convert(8'h01);
    abort_run(8'hFF);
    convert(8'h3C);
    for (int i = 0; i < 6; i++) convert(8'((i * 47 + 13) & 8'hFF));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule